// File: doc/BRIEF.md
# Bit-Field Place Unit

This datapath writes a short bit field into a destination word. The destination comes in on one operand. The second operand carries three things: the field bits in its low end, a 4-bit length code, and a rotate amount. The result is the destination word with one window replaced. The window has the requested length and starts at the requested bit position. If the window runs past the top bit, it continues from bit 0. This is because both the field bits and the window mask are rotated, not shifted.

A word-mode input selects a 32-bit variant. In this mode the placement happens inside the low 32 bits, and the 32-bit result is sign-extended to 64 bits. A parameter chooses whether the result goes through one register stage (the default) or leaves combinationally.

Top module: `bitfield_place`

## Requirements
- R1: The field width comes from the length code in bits [27:24] of the control operand, read as an unsigned value from 1 to 15. A code of 0 gives a width of 16.
- R2: The start position is bits [21:16] of the control operand in 64-bit mode. In word mode it is bits [20:16], and bit 21 is ignored.
- R3: Field bits that would land above the top bit of the active width (bit 63, or bit 31 in word mode) wrap around and continue from bit 0.
- R4: The placed bits are the lowest field-width bits of the control operand. Bit i of the field lands at position (start + i) modulo the active width.
- R5: Every result bit outside the placed window equals the matching destination bit.
- R6: In word mode, result bits [63:32] all equal result bit 31. Bits [63:32] of both operands have no effect on the result.
- R7: A start position of 0 places the field at bit 0 with no wrap-around bits.
- R8: In 64-bit mode, control operand bits [63:28], [23:22] and [15:width] have no effect on the result.
- R9: With the register stage present, the result appears one clock after the operands are applied. An active-low reset clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| dst_i | input | 64 | Destination word |
| src_i | input | 64 | Field bits [15:0], start position [21:16], length code [27:24] |
| word_mode_i | input | 1 | 1 selects the 32-bit variant with sign extension |
| result_o | output | 64 | Destination word with the field inserted |

## Verification
The assertions expect the operands and the word-mode flag to be driven to known values on every clock after reset. They place no other limit on inputs, because every length code and start position is legal. The stimulus changes inputs only on the falling edge, so each vector is stable across the capturing edge. It covers all 16 length codes and start positions up to 63, including the wrapping cases at start 60 and at word start 28. It also fills the ignored operand bits with random values so that any dependence on them shows up in the result.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    localparam int unsigned XLEN    = 64;
    localparam int unsigned HLEN    = XLEN / 2;
    localparam int unsigned LEN_W   = 4;
    localparam int unsigned LEN_LSB = 24;
    localparam int unsigned OFF_LSB = 16;
    localparam int unsigned OFF_W   = $clog2(XLEN);

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        word_t result;
    } out_stage_t;
endpackage

// File: rtl/bfp_field_mask.sv
module bfp_field_mask #(
    parameter int unsigned LEN_W = 4,
    parameter int unsigned W     = 64
) (
    input  logic [LEN_W-1:0] len_code_i,
    output logic [W-1:0]     mask_o
);
    localparam int unsigned MAX_LEN = 1 << LEN_W;

    int unsigned width;

    always_comb begin
        width = (len_code_i == '0) ? MAX_LEN : int'(len_code_i);
        for (int i = 0; i < int'(W); i++) begin
            mask_o[i] = (i < int'(width));
        end
    end

    always_comb begin
        AST_MASK_WIDTH: assert ($countones(mask_o) == ((len_code_i == '0) ? MAX_LEN : int'(len_code_i))); // R1
        AST_MASK_LOW: assert (mask_o[0] == 1'b1); // R7
    end
endmodule

// File: rtl/bfp_rotl.sv
module bfp_rotl #(
    parameter int unsigned W  = 64,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  in_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  out_o
);
    logic [W-1:0] stage [AW+1];

    assign stage[0] = in_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned S = 1 << k;
        assign stage[k+1] = amt_i[k] ? {stage[k][W-S-1:0], stage[k][W-1:W-S]} : stage[k];
    end

    assign out_o = stage[AW];

    always_comb begin
        AST_ROT_POPCOUNT: assert ($countones(out_o) == $countones(in_i)); // R3
        AST_ROT_ZERO: assert ((amt_i != '0) || (out_o == in_i)); // R7
    end
endmodule

// File: rtl/bfp_merge.sv
module bfp_merge #(
    parameter int unsigned W = 64,
    parameter int unsigned H = W / 2
) (
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] mask_i,
    input  logic         word_mode_i,
    output logic [W-1:0] result_o
);
    logic [W-1:0] full_r;
    logic [H-1:0] half_r;

    always_comb begin
        full_r = (data_i & mask_i) | (dst_i & ~mask_i);
        half_r = full_r[H-1:0];
        if (word_mode_i) begin
            result_o = {{H{half_r[H-1]}}, half_r};
        end else begin
            result_o = full_r;
        end
    end

    always_comb begin
        AST_KEEP_DST: assert (word_mode_i || (((result_o ^ dst_i) & ~mask_i) == '0)); // R5
        AST_WORD_KEEP_DST: assert (!word_mode_i || ((((result_o ^ dst_i) & ~mask_i) & {{H{1'b0}}, {H{1'b1}}}) == '0)); // R5
    end
endmodule

// File: rtl/bitfield_place.sv
module bitfield_place
    import bfp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] dst_i,
    input  logic [XLEN-1:0] src_i,
    input  logic            word_mode_i,
    output logic [XLEN-1:0] result_o
);
    logic [LEN_W-1:0] len_code;
    logic [OFF_W-1:0] rot_amt;
    word_t            mask_base;
    word_t            mask_pre;
    word_t            data_pre;
    word_t            mask_rot;
    word_t            data_rot;
    word_t            merged;
    out_stage_t       st_d;

    // Field decode; word mode replicates the low half so a 64-bit rotate
    // yields a 32-bit rotate in its low half.
    always_comb begin
        len_code = src_i[LEN_LSB +: LEN_W];
        if (word_mode_i) begin
            rot_amt  = {1'b0, src_i[OFF_LSB +: OFF_W-1]};
            data_pre = {src_i[HLEN-1:0], src_i[HLEN-1:0]};
            mask_pre = {mask_base[HLEN-1:0], mask_base[HLEN-1:0]};
        end else begin
            rot_amt  = src_i[OFF_LSB +: OFF_W];
            data_pre = src_i;
            mask_pre = mask_base;
        end
    end

    bfp_field_mask #(.LEN_W(LEN_W), .W(XLEN)) u_mask (
        .len_code_i (len_code),
        .mask_o     (mask_base)
    );

    bfp_rotl #(.W(XLEN), .AW(OFF_W)) u_rot_mask (
        .in_i  (mask_pre),
        .amt_i (rot_amt),
        .out_o (mask_rot)
    );

    bfp_rotl #(.W(XLEN), .AW(OFF_W)) u_rot_data (
        .in_i  (data_pre),
        .amt_i (rot_amt),
        .out_o (data_rot)
    );

    bfp_merge #(.W(XLEN), .H(HLEN)) u_merge (
        .dst_i       (dst_i),
        .data_i      (data_rot),
        .mask_i      (mask_rot),
        .word_mode_i (word_mode_i),
        .result_o    (merged)
    );

    always_comb begin
        st_d        = '0;
        st_d.result = merged;
    end

    if (REG_OUT) begin : g_reg
        out_stage_t st_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign result_o = st_q.result;

        AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
            word_mode_i |=> (result_o[XLEN-1:HLEN] == {HLEN{result_o[HLEN-1]}})); // R6
        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |-> (result_o == '0)); // R9
    end else begin : g_comb
        assign result_o = st_d.result;
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
    end
endmodule

// File: tb/bitfield_place_tb.sv
module bitfield_place_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic        word_mode_i = 1'b0;
    logic [63:0] result_o;

    int unsigned tests = 0;
    int unsigned fails = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    bitfield_place u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dst_i       (dst_i),
        .src_i       (src_i),
        .word_mode_i (word_mode_i),
        .result_o    (result_o)
    );

    function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] s, input logic wm);
        int          width;
        int          w;
        int          off;
        logic [63:0] r;
        width = (s[27:24] == 4'd0) ? 16 : int'(s[27:24]);
        w     = wm ? 32 : 64;
        off   = wm ? int'(s[20:16]) : int'(s[21:16]);
        r     = d;
        for (int i = 0; i < width; i++) begin
            r[(off + i) % w] = s[i];
        end
        if (wm) r = {{32{r[31]}}, r[31:0]};
        return r;
    endfunction

    function automatic logic [63:0] ctl(input int len, input int off, input logic [15:0] data);
        logic [63:0] v;
        v = '0;
        v[27:24] = len[3:0];
        v[21:16] = off[5:0];
        v[15:0]  = data;
        return v;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: result %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [63:0] d, input logic [63:0] s, input logic wm, input string tag);
        @(negedge clk);
        if (exp_q.size() > 0) check(result_o, exp_q.pop_front(), tag_q.pop_front());
        dst_i       = d;
        src_i       = s;
        word_mode_i = wm;
        exp_q.push_back(model(d, s, wm));
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        while (exp_q.size() > 0) check(result_o, exp_q.pop_front(), tag_q.pop_front());
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: result %h expected completion", result_o);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        dst_i = 64'hFFFF_FFFF_FFFF_FFFF;
        src_i = 64'h0F3C_0000_0A3F_1234;
        repeat (3) @(negedge clk);
        check(result_o, 64'h0, "R9 reset clear");
        rst_n = 1'b1;

        // R1 length decode: code 0 -> 16, 1, 15
        step(64'h0, ctl(0, 0, 16'hFFFF), 1'b0, "R1 len0=16");
        step(64'h0, ctl(1, 4, 16'hFFFF), 1'b0, "R1 len1");
        step(64'h0, ctl(15, 8, 16'hFFFF), 1'b0, "R1 len15");
        // R7 offset zero, no wrap
        step(64'hAAAA_AAAA_AAAA_AAAA, ctl(8, 0, 16'h00C3), 1'b0, "R7 off0");
        step(64'hAAAA_AAAA_AAAA_AAAA, ctl(8, 0, 16'h00C3), 1'b1, "R7 off0 word");
        // R3 wrap across the top
        step(64'h1234_5678_9ABC_DEF0, ctl(8, 60, 16'h00A5), 1'b0, "R3 wrap off60 len8");
        step(64'h1234_5678_9ABC_DEF0, ctl(8, 28, 16'h00A5), 1'b1, "R3 wrap word off28 len8");
        step(64'h0, ctl(0, 63, 16'h8001), 1'b0, "R3 wrap off63 len16");
        // R2 word mode ignores offset bit 21
        step(64'h0, ctl(4, 37, 16'h000F), 1'b1, "R2 word ignores bit21");
        step(64'h0, ctl(4, 37, 16'h000F), 1'b0, "R2 full uses bit21");
        // R5 bits outside the window keep dst
        step(64'hFFFF_FFFF_FFFF_FFFF, ctl(5, 20, 16'h0000), 1'b0, "R5 keep dst");
        // R6 word mode sign extension and upper operand bits ignored
        step(64'h5555_5555_0000_0000, {32'hDEAD_BEEF, ctl(4, 28, 16'h0008)}, 1'b1, "R6 sext negative");
        step(64'hFFFF_FFFF_0000_0000, {32'hFFFF_FFFF, ctl(4, 0, 16'h0001)}, 1'b1, "R6 sext positive");
        // R8 ignored control bits in full mode
        step(64'h0, 64'hF0F0_F0F0_F0C0_FFFF | ctl(3, 12, 16'h0005), 1'b0, "R8 ignored bits");
        // R4 random placement
        for (int n = 0; n < 400; n++) begin
            step({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R4 random");
        end
        flush();

        // R9 reset clears the stage again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result_o, 64'h0, "R9 reset mid-run");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule